// File: doc/BRIEF.md
# Trace Capture Qualifier

This block sits in front of a trace buffer and decides, one bus command at a time, whether that command gets recorded. A command is presented for one cycle with an opcode, a source ID, a destination ID and an address. Three matchers look at it. The filter matcher selects the commands of interest. The start-trigger matcher opens a capture window and the stop-trigger matcher closes it. Each matcher has its own opcode bitmask, source bitmask, destination bitmask, and masked address compare. The four field tests are ANDed together.

With triggers disabled, every command that hits the filter is recorded. With triggers enabled, recording happens only inside the window, and only for commands that hit at least one of the three matchers. Two opcodes are reserved for idle and response cycles and are never recorded and never trigger. A fill counter tracks how many commands have been recorded since tracing was last enabled. In single-fill mode, recording stops once that count reaches the buffer depth. In wrap mode, recording never stops.

The result is a one-cycle capture pulse, registered one clock after the command, together with a registered status bit showing whether the trigger window is open. Configuration and the trace enable are plain inputs held by a register block elsewhere.

Top module: `trc_capture_gate`

## Requirements
- R1: After synchronous reset, `cap_o` and `win_o` are both 0.
- R2: While `trc_en` is 0, no command is captured. The window and the fill count are cleared, so each new enable starts with a closed window and an empty count.
- R3: With `trig_en` at 0, a valid command raises `cap_o` in the following cycle exactly when all four filter field tests pass: `flt_op_mask[cmd_op]`, `flt_src_mask[cmd_src]` and `flt_dst_mask[cmd_dst]` are all 1, and the address test of R4 passes. No pulse follows a cycle in which `cmd_vld` is 0.
- R4: The address test of a matcher passes when `(cmd_addr & mask) == (value & mask)`. A zero mask therefore passes any address.
- R5: Opcodes 0 (idle) and 1 (response) are never captured and never open or close the window, whatever the masks say.
- R6: With triggers enabled, a command that hits the start trigger is itself captured, and `win_o` reads 1 from the next cycle.
- R7: With the window open, a command that hits the stop trigger is captured, and `win_o` reads 0 from the next cycle.
- R8: While the window is open, a command is captured if it hits the filter, the start trigger or the stop trigger, and is dropped otherwise.
- R9: While the window is closed, a command that hits neither trigger's start condition is not captured, even if it hits the filter or the stop trigger.
- R10: While the window is closed, a single command that hits both start and stop is captured, and the window stays closed.
- R11: With `wrap_en` at 0, at most DEPTH commands are captured after an enable. With `wrap_en` at 1, capture is not limited by the count.
- R12: While `trig_en` is 0, `win_o` is held at 0 and the window state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_en | input | 1 | Tracing enable |
| trig_en | input | 1 | Use the start/stop window |
| wrap_en | input | 1 | 1: unlimited capture; 0: stop after DEPTH captures |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_op | input | 6 | Command opcode |
| cmd_src | input | 5 | Source ID |
| cmd_dst | input | 5 | Destination ID |
| cmd_addr | input | 38 | Command address |
| flt_op_mask | input | 64 | Filter opcode bitmask |
| flt_src_mask | input | 32 | Filter source bitmask |
| flt_dst_mask | input | 32 | Filter destination bitmask |
| flt_addr | input | 38 | Filter address value |
| flt_addr_mask | input | 38 | Filter address mask |
| str_op_mask | input | 64 | Start-trigger opcode bitmask |
| str_src_mask | input | 32 | Start-trigger source bitmask |
| str_dst_mask | input | 32 | Start-trigger destination bitmask |
| str_addr | input | 38 | Start-trigger address value |
| str_addr_mask | input | 38 | Start-trigger address mask |
| stp_op_mask | input | 64 | Stop-trigger opcode bitmask |
| stp_src_mask | input | 32 | Stop-trigger source bitmask |
| stp_dst_mask | input | 32 | Stop-trigger destination bitmask |
| stp_addr | input | 38 | Stop-trigger address value |
| stp_addr_mask | input | 38 | Stop-trigger address mask |
| cap_o | output | 1 | Capture pulse for the command of the previous cycle |
| win_o | output | 1 | Trigger window open |

## Verification
Both outputs come from registers. The capture decision for a command presented in cycle t appears on `cap_o` in cycle t+1. The window state that the same command leaves behind appears on `win_o` in cycle t+1.

The bench drives each command on a falling edge. Its reference model advances on the rising edge that samples that command. Both outputs are then compared with the model on the following falling edge, so every result is checked in exactly the cycle it is due.

Under the single-fill limit, the capture that brings the count to DEPTH is still seen. Only commands after it are refused, and this is checked command by command.

// File: rtl/trc_pkg.sv
package trc_pkg;

    // Command field widths shared by the whole trace path
    localparam int TRC_OP_W   = 6;
    localparam int TRC_SRC_W  = 5;
    localparam int TRC_DST_W  = 5;
    localparam int TRC_ADDR_W = 38;

    // Mask widths derived from the code widths: one bit per code
    localparam int TRC_OP_N  = 1 << TRC_OP_W;
    localparam int TRC_SRC_N = 1 << TRC_SRC_W;
    localparam int TRC_DST_N = 1 << TRC_DST_W;

    // Number of matchers: filter, start trigger, stop trigger
    localparam int TRC_NMATCH = 3;

    typedef enum int {
        MT_FILT  = 0,
        MT_START = 1,
        MT_STOP  = 2
    } trc_matcher_e;

    typedef struct packed {
        logic [TRC_OP_W-1:0]   op;
        logic [TRC_SRC_W-1:0]  src;
        logic [TRC_DST_W-1:0]  dst;
        logic [TRC_ADDR_W-1:0] addr;
    } trc_cmd_t;

    typedef struct packed {
        logic [TRC_OP_N-1:0]   op_mask;
        logic [TRC_SRC_N-1:0]  src_mask;
        logic [TRC_DST_N-1:0]  dst_mask;
        logic [TRC_ADDR_W-1:0] addr_val;
        logic [TRC_ADDR_W-1:0] addr_mask;
    } trc_match_cfg_t;

    typedef struct packed {
        logic filt;
        logic start;
        logic stop;
    } trc_hits_t;

    // Masked address equality: only bits set in the mask take part
    function automatic logic trc_addr_eq(
        input logic [TRC_ADDR_W-1:0] a,
        input logic [TRC_ADDR_W-1:0] v,
        input logic [TRC_ADDR_W-1:0] m
    );
        return ((a ^ v) & m) == '0;
    endfunction

    // Select the bit of a one-hot style mask addressed by a code
    function automatic logic trc_bit_sel_op(
        input logic [TRC_OP_N-1:0] mask,
        input logic [TRC_OP_W-1:0] code
    );
        return mask[code];
    endfunction

endpackage

// File: rtl/trc_field_match.sv
module trc_field_match
    import trc_pkg::*;
(
    input  trc_cmd_t       cmd,
    input  trc_match_cfg_t cfg,
    output logic           hit
);

    logic op_ok;
    logic src_ok;
    logic dst_ok;
    logic addr_ok;

    always_comb begin
        op_ok   = trc_bit_sel_op(cfg.op_mask, cmd.op);
        src_ok  = cfg.src_mask[cmd.src];
        dst_ok  = cfg.dst_mask[cmd.dst];
        addr_ok = trc_addr_eq(cmd.addr, cfg.addr_val, cfg.addr_mask);
    end

    assign hit = op_ok & src_ok & dst_ok & addr_ok;

endmodule

// File: rtl/trc_window.sv
module trc_window
    import trc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trc_en,
    input  logic      trig_en,
    input  trc_hits_t hits,     // already qualified by command legality
    output logic      win_eff,  // window seen by the current command
    output logic      win_q     // window state after the last command
);

    logic open_q;

    // The start command is inside the window it opens
    assign win_eff = open_q | hits.start;

    always_ff @(posedge clk) begin
        if (rst || !trc_en || !trig_en) begin
            open_q <= 1'b0;
        end else if (hits.stop && win_eff) begin
            open_q <= 1'b0;
        end else if (hits.start) begin
            open_q <= 1'b1;
        end
    end

    assign win_q = open_q;

endmodule

// File: rtl/trc_fill.sv
module trc_fill #(
    parameter int DEPTH = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic trc_en,
    input  logic wrap_en,
    input  logic cap,
    output logic room
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full = (cnt_q == CNT_MAX);

    // Count saturates at DEPTH: once filled, only wrap mode permits more
    always_ff @(posedge clk) begin
        if (rst || !trc_en) begin
            cnt_q <= '0;
        end else if (cap && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign room = wrap_en | ~full;

endmodule

// File: rtl/trc_capture_gate.sv
module trc_capture_gate
    import trc_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int IDLE_OP = 0,
    parameter int RESP_OP = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trc_en,
    input  logic                  trig_en,
    input  logic                  wrap_en,
    input  logic                  cmd_vld,
    input  logic [TRC_OP_W-1:0]   cmd_op,
    input  logic [TRC_SRC_W-1:0]  cmd_src,
    input  logic [TRC_DST_W-1:0]  cmd_dst,
    input  logic [TRC_ADDR_W-1:0] cmd_addr,
    input  logic [TRC_OP_N-1:0]   flt_op_mask,
    input  logic [TRC_SRC_N-1:0]  flt_src_mask,
    input  logic [TRC_DST_N-1:0]  flt_dst_mask,
    input  logic [TRC_ADDR_W-1:0] flt_addr,
    input  logic [TRC_ADDR_W-1:0] flt_addr_mask,
    input  logic [TRC_OP_N-1:0]   str_op_mask,
    input  logic [TRC_SRC_N-1:0]  str_src_mask,
    input  logic [TRC_DST_N-1:0]  str_dst_mask,
    input  logic [TRC_ADDR_W-1:0] str_addr,
    input  logic [TRC_ADDR_W-1:0] str_addr_mask,
    input  logic [TRC_OP_N-1:0]   stp_op_mask,
    input  logic [TRC_SRC_N-1:0]  stp_src_mask,
    input  logic [TRC_DST_N-1:0]  stp_dst_mask,
    input  logic [TRC_ADDR_W-1:0] stp_addr,
    input  logic [TRC_ADDR_W-1:0] stp_addr_mask,
    output logic                  cap_o,
    output logic                  win_o
);

    localparam logic [TRC_OP_W-1:0] OP_IDLE = TRC_OP_W'(IDLE_OP);
    localparam logic [TRC_OP_W-1:0] OP_RESP = TRC_OP_W'(RESP_OP);

    trc_cmd_t                  cmd;
    trc_match_cfg_t            cfg [TRC_NMATCH];
    logic [TRC_NMATCH-1:0]     raw_hit;
    trc_hits_t                 hits;
    logic                      legal;
    logic                      win_eff;
    logic                      win_q;
    logic                      room;
    logic                      want;
    logic                      cap_d;
    logic                      cap_q;

    assign cmd = '{op: cmd_op, src: cmd_src, dst: cmd_dst, addr: cmd_addr};

    assign cfg[MT_FILT]  = '{op_mask: flt_op_mask, src_mask: flt_src_mask,
                             dst_mask: flt_dst_mask, addr_val: flt_addr,
                             addr_mask: flt_addr_mask};
    assign cfg[MT_START] = '{op_mask: str_op_mask, src_mask: str_src_mask,
                             dst_mask: str_dst_mask, addr_val: str_addr,
                             addr_mask: str_addr_mask};
    assign cfg[MT_STOP]  = '{op_mask: stp_op_mask, src_mask: stp_src_mask,
                             dst_mask: stp_dst_mask, addr_val: stp_addr,
                             addr_mask: stp_addr_mask};

    // One identical matcher per configuration set
    for (genvar g = 0; g < TRC_NMATCH; g++) begin : g_match
        trc_field_match u_match (
            .cmd (cmd),
            .cfg (cfg[g]),
            .hit (raw_hit[g])
        );
    end

    // Reserved idle/response opcodes never match anything
    assign legal = cmd_vld && (cmd_op != OP_IDLE) && (cmd_op != OP_RESP);

    always_comb begin
        hits.filt  = legal & raw_hit[MT_FILT];
        hits.start = legal & raw_hit[MT_START];
        hits.stop  = legal & raw_hit[MT_STOP];
    end

    trc_window u_window (
        .clk     (clk),
        .rst     (rst),
        .trc_en  (trc_en),
        .trig_en (trig_en),
        .hits    (hits),
        .win_eff (win_eff),
        .win_q   (win_q)
    );

    always_comb begin
        if (trig_en) begin
            want = win_eff & (hits.filt | hits.start | hits.stop);
        end else begin
            want = hits.filt;
        end
        cap_d = trc_en & want & room;
    end

    trc_fill #(
        .DEPTH (DEPTH)
    ) u_fill (
        .clk     (clk),
        .rst     (rst),
        .trc_en  (trc_en),
        .wrap_en (wrap_en),
        .cap     (cap_d),
        .room    (room)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_o = cap_q;
    assign win_o = win_q;

endmodule

// File: rtl/trc_capture_gate_chk.sv
module trc_capture_gate_chk
    import trc_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int IDLE_OP = 0,
    parameter int RESP_OP = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                trc_en,
    input logic                trig_en,
    input logic                wrap_en,
    input logic                cmd_vld,
    input logic [TRC_OP_W-1:0] cmd_op,
    input logic                cap_o,
    input logic                win_o
);

    // Captures observed at the output since the last enable, saturating
    int seen;

    always_ff @(posedge clk) begin
        if (rst || !trc_en) begin
            seen <= 0;
        end else if (cap_o && seen < DEPTH) begin
            seen <= seen + 1;
        end
    end

    a_r2_off_no_cap: assert property (@(posedge clk) disable iff (rst)
        !trc_en |=> !cap_o);

    a_r2_off_closed: assert property (@(posedge clk) disable iff (rst)
        !trc_en |=> !win_o);

    a_r3_no_cmd_no_cap: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld |=> !cap_o);

    a_r5_reserved_op: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && (cmd_op == TRC_OP_W'(IDLE_OP) || cmd_op == TRC_OP_W'(RESP_OP)))
        |=> !cap_o);

    a_r12_trig_off_closed: assert property (@(posedge clk) disable iff (rst)
        !trig_en |=> !win_o);

    a_r6_open_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(win_o) |-> $past(trc_en && trig_en && cmd_vld));

    a_r11_fill_limit: assert property (@(posedge clk) disable iff (rst)
        (trc_en && !wrap_en && (seen + int'(cap_o)) >= DEPTH) |=> !cap_o);

endmodule

bind trc_capture_gate trc_capture_gate_chk #(
    .DEPTH   (DEPTH),
    .IDLE_OP (IDLE_OP),
    .RESP_OP (RESP_OP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .trc_en  (trc_en),
    .trig_en (trig_en),
    .wrap_en (wrap_en),
    .cmd_vld (cmd_vld),
    .cmd_op  (cmd_op),
    .cap_o   (cap_o),
    .win_o   (win_o)
);

// File: tb/trc_capture_gate_tb.sv
`timescale 1ns/1ps
module trc_capture_gate_tb;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trc_en = 1'b0;
    logic        trig_en = 1'b0;
    logic        wrap_en = 1'b1;
    logic        cmd_vld = 1'b0;
    logic [5:0]  cmd_op = '0;
    logic [4:0]  cmd_src = '0;
    logic [4:0]  cmd_dst = '0;
    logic [37:0] cmd_addr = '0;
    logic [63:0] b_opm  [3];
    logic [31:0] b_srcm [3];
    logic [31:0] b_dstm [3];
    logic [37:0] b_av   [3];
    logic [37:0] b_am   [3];
    logic        cap_o;
    logic        win_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    bit m_open = 0;
    int m_cnt  = 0;
    bit e_cap  = 0;
    bit e_win  = 0;

    always #2.5 clk = ~clk;

    trc_capture_gate #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .trc_en(trc_en), .trig_en(trig_en), .wrap_en(wrap_en),
        .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .cmd_addr(cmd_addr),
        .flt_op_mask(b_opm[0]), .flt_src_mask(b_srcm[0]), .flt_dst_mask(b_dstm[0]),
        .flt_addr(b_av[0]), .flt_addr_mask(b_am[0]),
        .str_op_mask(b_opm[1]), .str_src_mask(b_srcm[1]), .str_dst_mask(b_dstm[1]),
        .str_addr(b_av[1]), .str_addr_mask(b_am[1]),
        .stp_op_mask(b_opm[2]), .stp_src_mask(b_srcm[2]), .stp_dst_mask(b_dstm[2]),
        .stp_addr(b_av[2]), .stp_addr_mask(b_am[2]),
        .cap_o(cap_o), .win_o(win_o)
    );

    function automatic bit ref_hit(int k);
        return b_opm[k][cmd_op] && b_srcm[k][cmd_src] && b_dstm[k][cmd_dst]
            && ((cmd_addr & b_am[k]) == (b_av[k] & b_am[k]));
    endfunction

    task automatic model_step();
        bit ok, f, s, p, inwin, want;
        if (rst) begin
            m_open = 0; m_cnt = 0; e_cap = 0;
        end else if (!trc_en) begin
            m_open = 0; m_cnt = 0; e_cap = 0;
        end else begin
            ok = cmd_vld && cmd_op != 6'd0 && cmd_op != 6'd1;
            f = ok && ref_hit(0);
            s = ok && ref_hit(1);
            p = ok && ref_hit(2);
            inwin = m_open || s;
            want = trig_en ? (inwin && (f || s || p)) : f;
            e_cap = want && (wrap_en || m_cnt < DEPTH);
            if (!trig_en) m_open = 0;
            else if (p && inwin) m_open = 0;
            else if (s) m_open = 1;
            if (e_cap && m_cnt < DEPTH) m_cnt++;
        end
        e_win = m_open;
    endtask

    task automatic compare();
        n_chk++;
        if (cap_o !== e_cap) begin
            n_bad++;
            $display("FAIL %s cap_o actual=%b expected=%b t=%0t", cur_req, cap_o, e_cap, $time);
        end
        n_chk++;
        if (win_o !== e_win) begin
            n_bad++;
            $display("FAIL %s win_o actual=%b expected=%b t=%0t", cur_req, win_o, e_win, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic send(string req, int op, int src, int dst, logic [37:0] addr);
        cur_req  = req;
        cmd_vld  = 1'b1;
        cmd_op   = 6'(op);
        cmd_src  = 5'(src);
        cmd_dst  = 5'(dst);
        cmd_addr = addr;
        tick();
        cmd_vld  = 1'b0;
    endtask

    task automatic gap(string req);
        cur_req = req;
        cmd_vld = 1'b0;
        tick();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        // filter: ops 0,1,2,3 (0/1 reserved), sources 0..3, any dst, addr[17:12]==1
        b_opm[0]  = 64'h0F;  b_srcm[0] = 32'h0F; b_dstm[0] = '1;
        b_av[0]   = 38'h1000; b_am[0] = 38'h3F000;
        // start: ops 10,12; any src; dst 4 only; any address
        b_opm[1]  = (64'd1 << 10) | (64'd1 << 12); b_srcm[1] = '1;
        b_dstm[1] = 32'h10; b_av[1] = '0; b_am[1] = '0;
        // stop: ops 11,12; anything else
        b_opm[2]  = (64'd1 << 11) | (64'd1 << 12); b_srcm[2] = '1;
        b_dstm[2] = '1; b_av[2] = '0; b_am[2] = '0;

        @(negedge clk);
        for (int i = 0; i < 3; i++) gap("R1");
        rst = 1'b0;
        gap("R1");

        // R2: disabled tracing drops even perfect filter hits
        send("R2", 2, 0, 0, 38'h1000);
        send("R2", 3, 1, 2, 38'h1FFF);

        // triggers off, wrap on
        trc_en = 1'b1;
        gap("R2");
        send("R3", 2, 0, 5, 38'h1ABC);
        gap("R3");
        send("R3", 3, 3, 9, 38'h1000);
        send("R3", 4, 0, 0, 38'h1000);   // opcode not in mask
        send("R3", 2, 4, 0, 38'h1000);   // source not in mask
        send("R4", 2, 0, 0, 38'h2000);   // addr[17:12] wrong
        send("R4", 2, 0, 0, 38'h4_0000_1FFF); // high bits outside mask
        send("R5", 0, 0, 0, 38'h1000);
        send("R5", 1, 0, 0, 38'h1000);
        gap("R3");

        // triggers on
        trig_en = 1'b1;
        gap("R12");
        send("R9", 5, 0, 0, 38'h0);
        send("R9", 2, 0, 0, 38'h1000);
        send("R9", 11, 0, 0, 38'h0);
        send("R9", 10, 0, 3, 38'h0);     // start op but wrong dst
        send("R6", 10, 7, 4, 38'h0);
        send("R8", 2, 0, 0, 38'h1000);
        send("R8", 5, 0, 0, 38'h1000);
        send("R8", 2, 7, 0, 38'h1000);
        send("R8", 10, 0, 4, 38'h0);
        send("R5", 0, 0, 4, 38'h0);
        send("R5", 1, 0, 0, 38'h0);
        send("R7", 11, 9, 9, 38'h0);
        send("R9", 2, 0, 0, 38'h1000);
        send("R10", 12, 0, 4, 38'h0);
        send("R10", 2, 0, 0, 38'h1000);
        send("R6", 10, 0, 4, 38'h0);
        trig_en = 1'b0;
        gap("R12");
        send("R12", 2, 1, 1, 38'h1000);
        send("R12", 10, 0, 4, 38'h0);

        // R11: re-enable, single fill
        trc_en = 1'b0;
        gap("R2");
        trc_en = 1'b1;
        wrap_en = 1'b0;
        for (int i = 0; i < 12; i++) send("R11", 2, i % 4, i, 38'h1000);
        gap("R11");
        wrap_en = 1'b1;
        for (int i = 0; i < 4; i++) send("R11", 3, 0, 0, 38'h1000);
        trc_en = 1'b0;
        gap("R2");
        trc_en = 1'b1;
        wrap_en = 1'b0;
        send("R2", 2, 0, 0, 38'h1000);
        gap("R11");

        done = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

endmodule